// File: doc/BRIEF.md
# Level and Pulse-Width Trigger

This block watches one of two unsigned sample streams and raises a single-cycle trigger pulse when the selected stream crosses a programmable threshold. In level mode it fires on each crossing in the chosen direction. In the two width modes, the chosen crossing opens a pulse and the opposite crossing closes it. The block counts how many samples the pulse lasted. It fires at the closing sample if that count is shorter than a reference, or, in the other width mode, at least as long as the reference.

Samples are qualified by a valid strobe, so the block can sit behind a decimating sample clock. The threshold, slope, source, mode and width reference are plain static inputs, normally driven from configuration registers elsewhere.

Top module: `level_width_trigger`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `trig_o` is 0.
- R2: A sample counts as high when it is greater than or equal to `thresh_i`, compared as unsigned `SAMPLE_W`-bit numbers, and as low otherwise. This holds at threshold values 1 and 2^SAMPLE_W-1.
- R3: In mode 00 (level), `trig_o` is 1 for exactly one cycle, in the cycle after the valid sample that completes a crossing. With `rising_i`=1 the crossing is low-to-high, and with `rising_i`=0 it is high-to-low. A crossing in the other direction does not fire.
- R4: `src_sel_i`=00 selects `ch0_i` and `src_sel_i`=01 selects `ch1_i`. Codes 10 and 11 never fire the trigger.
- R5: Mode 11 never fires the trigger.
- R6: In a width mode, the valid sample that makes the selected crossing counts as width 1. Each later valid sample on the same side adds 1. The count saturates at 2^CNT_W-1.
- R7: Mode 01 fires at the valid sample that makes the opposite crossing when the width is less than `width_ref_i`. Mode 10 fires there when the width is greater than or equal to `width_ref_i`. Neither mode fires at the opening sample or inside the pulse.
- R8: Samples presented with `valid_i`=0 neither fire the trigger nor change the stored previous level.
- R9: The first valid sample after reset has no predecessor and cannot complete a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ch0_i | input | SAMPLE_W | Channel 0 sample |
| ch1_i | input | SAMPLE_W | Channel 1 sample |
| valid_i | input | 1 | Sample-valid strobe |
| thresh_i | input | SAMPLE_W | Threshold |
| rising_i | input | 1 | Slope select, 1 = rising, 0 = falling |
| src_sel_i | input | 2 | Source select |
| mode_i | input | 2 | 00 level, 01 width less, 10 width greater-or-equal, 11 off |
| width_ref_i | input | CNT_W | Width reference in samples |
| trig_o | output | 1 | Trigger pulse |

## Verification
The bench builds the block with the default 10-bit samples and a 4-bit width counter. With a 4-bit counter, saturation at 15 is only a few samples away. Every width reference from 0 to 15 can then be swept against every pulse width from 1 to 17, in both width modes and both slopes, so every less-than and greater-or-equal boundary is hit, including widths beyond the saturation point. Level crossings are swept over both channels and both slopes, at the lowest and highest thresholds. The unselected channel always moves the opposite way, so a swapped source select fires on the wrong sample.

// File: rtl/lwt_pkg.sv
package lwt_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_SHORT = 2'b01,
    MODE_LONG  = 2'b10,
    MODE_OFF   = 2'b11
  } trig_mode_e;
endpackage

// File: rtl/lwt_cross_det.sv
module lwt_cross_det #(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thresh_i,
  input  logic                valid_i,
  input  logic                rising_i,
  output logic                lead_o,
  output logic                trail_o
);
  logic high_now, high_q, hist_q, up, dn;

  assign high_now = (sample_i >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_q <= 1'b0;
      hist_q <= 1'b0;
    end else if (valid_i) begin
      high_q <= high_now;
      hist_q <= 1'b1;
    end
  end

  // a crossing needs a previous valid sample
  assign up = valid_i & hist_q & ~high_q &  high_now;
  assign dn = valid_i & hist_q &  high_q & ~high_now;

  assign lead_o  = rising_i ? up : dn;
  assign trail_o = rising_i ? dn : up;

  AST_LEVEL_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(high_q)); // R8
endmodule

// File: rtl/lwt_width_ctr.sv
module lwt_width_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             lead_i,
  input  logic             trail_i,
  output logic             done_o,
  output logic [CNT_W-1:0] width_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (lead_i) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_ONE;
    end else if (trail_i && active_q) begin
      active_q <= 1'b0;
    end else if (valid_i && active_q && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign done_o  = trail_i & active_q;
  assign width_o = cnt_q;

  AST_CNT_STARTS_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i |=> (active_q && cnt_q == CNT_ONE)); // R6
  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && valid_i && !lead_i && !trail_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R6
endmodule

// File: rtl/level_width_trigger.sv
module level_width_trigger
  import lwt_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned CNT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] ch0_i,
  input  logic [SAMPLE_W-1:0] ch1_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] thresh_i,
  input  logic                rising_i,
  input  logic [1:0]          src_sel_i,
  input  logic [1:0]          mode_i,
  input  logic [CNT_W-1:0]    width_ref_i,
  output logic                trig_o
);
  logic [SAMPLE_W-1:0] sample;
  logic                src_ok, lead, trail, done, trig_d, trig_q;
  logic [CNT_W-1:0]    width;

  assign sample = src_sel_i[0] ? ch1_i : ch0_i;
  assign src_ok = ~src_sel_i[1];

  lwt_cross_det #(.SAMPLE_W(SAMPLE_W)) u_cross (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .thresh_i (thresh_i),
    .valid_i  (valid_i),
    .rising_i (rising_i),
    .lead_o   (lead),
    .trail_o  (trail)
  );

  lwt_width_ctr #(.CNT_W(CNT_W)) u_width (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .lead_i  (lead),
    .trail_i (trail),
    .done_o  (done),
    .width_o (width)
  );

  always_comb begin
    case (trig_mode_e'(mode_i))
      MODE_LEVEL: trig_d = lead;
      MODE_SHORT: trig_d = done & (width <  width_ref_i);
      MODE_LONG:  trig_d = done & (width >= width_ref_i);
      default:    trig_d = 1'b0;
    endcase
    trig_d = trig_d & src_ok & valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_d;
  end

  assign trig_o = trig_q;

  AST_TRIG_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(valid_i)); // R8
  AST_OFF_MODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> !trig_o); // R5
  AST_NO_SOURCE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_i[1] |=> !trig_o); // R4
  AST_LEVEL_NEEDS_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !lead) |=> !trig_o); // R3
endmodule

// File: tb/sim_level_width_trigger.sv
module sim_level_width_trigger;
  localparam int CLK_NS = 10;
  localparam int SW     = 10;
  localparam int CW     = 4;
  localparam int CMAX   = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] ch0 = '0, ch1 = '0, thr = '0;
  logic          valid = 1'b0, rising = 1'b0;
  logic [1:0]    src_sel = 2'b00, mode = 2'b00;
  logic [CW-1:0] wref = '0;
  logic          trig;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2) clk = ~clk;

  level_width_trigger #(.SAMPLE_W(SW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ch0_i(ch0), .ch1_i(ch1), .valid_i(valid),
    .thresh_i(thr), .rising_i(rising), .src_sel_i(src_sel), .mode_i(mode),
    .width_ref_i(wref), .trig_o(trig)
  );

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  // one sample; returns trig_o after the capturing edge
  task automatic drive(input logic [SW-1:0] a, input logic [SW-1:0] b, input bit v, output bit t);
    @(negedge clk);
    ch0 = a; ch1 = b; valid = v;
    @(posedge clk);
    #1 t = trig;
    @(negedge clk);
    valid = 1'b0;
  endtask

  // selected channel high/low; the other channel mirrors it
  task automatic smp(input bit hi, output bit t);
    logic [SW-1:0] h, l;
    h = thr; l = thr - 1'b1;
    if (src_sel == 2'b01) drive(hi ? l : h, hi ? h : l, 1'b1, t);
    else                  drive(hi ? h : l, hi ? l : h, 1'b1, t);
  endtask

  initial begin
    #(CLK_NS * 190000);
    checks++; errors++;
    $display("FAIL watchdog: got=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit t, early;
    thr = 10'd300; rising = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk(trig, 1'b0, "R1", "in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk(trig, 1'b0, "R1", "after reset");

    // R9: first sample high, no predecessor
    smp(1'b1, t); chk(t, 1'b0, "R9", "first sample");
    smp(1'b0, t); chk(t, 1'b0, "R3", "falling not selected");
    smp(1'b1, t); chk(t, 1'b1, "R3", "rising crossing");

    // R8: invalid low sample must not move history
    drive(10'd0, 10'd0, 1'b0, t); chk(t, 1'b0, "R8", "invalid sample");
    smp(1'b1, t); chk(t, 1'b0, "R8", "history kept");

    // R2 R3 R4: level sweep
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 2; r++)
        for (int k = 0; k < 3; k++) begin
          src_sel = 2'(s); rising = r[0];
          thr = (k == 0) ? 10'd1 : (k == 1) ? 10'd300 : 10'd1023;
          smp(!rising, t);
          smp(!rising, t); chk(t, 1'b0, "R3", "idle level");
          smp(rising, t);  chk(t, 1'b1, "R2", "selected crossing");
          smp(rising, t);  chk(t, 1'b0, "R3", "no repeat");
          smp(!rising, t); chk(t, 1'b0, "R4", "opposite crossing");
        end

    // R4: no source; R5: mode off
    thr = 10'd300; rising = 1'b1;
    for (int c = 0; c < 3; c++) begin
      src_sel = (c == 0) ? 2'b10 : (c == 1) ? 2'b11 : 2'b00;
      mode    = (c == 2) ? 2'b11 : 2'b00;
      early = 1'b0;
      for (int i = 0; i < 4; i++) begin smp(i[0], t); early |= t; end
      chk(early, 1'b0, (c == 2) ? "R5" : "R4", "silenced trigger");
    end

    // R6 R7: width sweep
    thr = 10'd300;
    for (int m = 1; m <= 2; m++)
      for (int r = 0; r < 2; r++)
        for (int ref_w = 0; ref_w <= CMAX; ref_w++)
          for (int n = 1; n <= CMAX + 2; n++) begin
            int w;
            bit exp;
            mode = 2'(m); rising = r[0]; wref = CW'(ref_w);
            src_sel = 2'(ref_w % 2);
            w = (n > CMAX) ? CMAX : n;
            exp = (m == 1) ? (w < ref_w) : (w >= ref_w);
            smp(!rising, t);
            early = 1'b0;
            smp(!rising, t); early |= t;
            for (int i = 0; i < n; i++) begin smp(rising, t); early |= t; end
            chk(early, 1'b0, "R7", $sformatf("inside pulse m=%0d n=%0d", m, n));
            smp(!rising, t);
            chk(t, exp, (n > CMAX) ? "R6" : "R7",
                $sformatf("pulse end m=%0d r=%0d ref=%0d n=%0d", m, r, ref_w, n));
          end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule